// File: doc/BRIEF.md
# Instruction Miss Service Responder

This block answers instruction-cache miss requests on behalf of the memory-management side. When the cache controller raises its miss request, the responder samples a set of per-request settings that stand in for translation and memory: whether the request aborts, whether a page-table entry applies, the entry's access and cacheable bits, its level, two latency values, the requested doubleword, a line address and an injected parity pattern. It then answers with either a one-cycle abort or a one-cycle status-available strobe. After the strobe, the status goes onto a shared bus for one cycle, and the fill data follows as 64-bit doubleword strobes.

A cacheable request returns a whole line of four doublewords. The fill starts at the requested doubleword and wraps through the line. A noncacheable request returns only the requested doubleword. Every edge of the exchange keeps a minimum spacing, and each configured latency adds cycles on top of that minimum. For this reason no setting can break the timing the cache controller relies on. The fill data is a computed pattern. A parity flag for each 32-bit word follows each doubleword by one cycle.

Top module: `imiss_responder`

## Requirements
- R1: While reset is held, and in the idle cycles after it, `stat_avail`, `abort`, `fill_stb`, `stat_bus`, `fill_data` and `fill_perr` are all zero.
- R2: For a request that does not abort, `stat_avail` is high for exactly one cycle. That cycle comes 1 + `cfg_stat_lat` cycles after the first cycle in which `miss_req` is high, so it is never earlier than the request's second cycle. `miss_req` is still high in that cycle.
- R3: In the cycle after `stat_avail`, `stat_bus` carries the status as {level[5:4], access[3:1], cacheable[0]}. In every cycle that is neither this one nor an abort cycle, `stat_bus` is zero.
- R4: When `cfg_pte_valid` is 0, the status carries access 3'b111 and cacheable 1, whatever `cfg_acc` and `cfg_cacheable` hold, and the request is served as a four-doubleword fill.
- R5: For an aborting request, `abort` is high for one cycle, at the cycle where `stat_avail` would otherwise have come. In that cycle `stat_bus` holds the level in [5:4] with [3:0] zero. No `stat_avail` and no `fill_stb` follow that request.
- R6: The first `fill_stb` comes 2 + `cfg_fill_lat` cycles after `stat_avail`.
- R7: A cacheable request produces exactly four `fill_stb` cycles. In each one, `fill_data[31:0]` equals {`cfg_line`, doubleword index} zero-extended, and `fill_data[63:32]` is its bitwise inverse. `fill_data` is zero in all other cycles.
- R8: Successive strobes of one line are 3 + `cfg_fill_lat` cycles apart, leaving at least two empty cycles between them.
- R9: The strobes of a cacheable fill carry `fill_dw` = `cfg_dw`, `cfg_dw`+1, and so on, modulo four. The fill ends on the strobe just before the index would return to `cfg_dw`.
- R10: A noncacheable request (entry applies, `cfg_cacheable` 0) produces exactly one `fill_stb`, with `fill_dw` = `cfg_dw`.
- R11: In the cycle after a strobe, `fill_perr` equals `cfg_perr` (bit 1 = word [63:32], bit 0 = word [31:0]) if that strobe's index equals `cfg_perr_dw`, and zero otherwise.
- R12: While a request is being served, a `miss_req` that stays high starts no second status or abort. The responder is idle again in the cycle after its final strobe or its abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_req | input | 1 | Miss request from the cache controller |
| cfg_abort | input | 1 | The request ends in an abort |
| cfg_cacheable | input | 1 | Cacheable bit of the page-table entry |
| cfg_pte_valid | input | 1 | A page-table entry applies to the request |
| cfg_acc | input | 3 | Access field of the page-table entry |
| cfg_lvl | input | 2 | Level field reported with status or abort |
| cfg_stat_lat | input | LAT_W | Extra cycles before status or abort |
| cfg_fill_lat | input | LAT_W | Extra cycles before each fill strobe |
| cfg_dw | input | log2(LINE_DW) | Requested doubleword index |
| cfg_line | input | LINE_W | Line address used for the data pattern |
| cfg_perr_dw | input | log2(LINE_DW) | Doubleword that carries injected parity errors |
| cfg_perr | input | DATA_W/32 | Per-word parity error pattern to inject |
| stat_avail | output | 1 | Status-available strobe |
| abort | output | 1 | Abort strobe |
| stat_bus | output | 6 | Status bus {level, access, cacheable} |
| fill_stb | output | 1 | Fill doubleword strobe |
| fill_dw | output | log2(LINE_DW) | Index of the doubleword on the fill bus |
| fill_data | output | DATA_W | Fill data |
| fill_perr | output | DATA_W/32 | Per-word parity flags, one cycle after the data |

## Verification
The bench aims at the wrap of a cacheable fill that starts in mid-line. A pointer that does not wrap, or that ends on the wrong compare, gives the wrong indices or a count other than four. Fill latency is varied so that the spacing rule is tested both at its minimum and with slack added. A design that counted the gap from the wrong cycle would strobe one cycle early and break the two empty cycles after each write. The abort path is checked for both a level-only status and a complete lack of strobes afterwards, and a request held high through a whole fill would show any premature re-accept as a second status pulse. Parity is injected on one chosen doubleword, so a flag that lands on the wrong cycle or the wrong word is seen.

// File: rtl/imr_pkg.sv
package imr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RESP = 2'd1,
      ST_BUS  = 2'd2,
      ST_FILL = 2'd3
   } imr_state_t;

   // status bus layout: {level, access, cacheable}
   typedef struct packed {
      logic [1:0] lvl;
      logic [2:0] acc;
      logic       cache;
   } imr_stat_t;

   localparam int STAT_W      = $bits(imr_stat_t);
   localparam int WORD_W      = 32;
   // cycles of silence required after a fill strobe, beyond the strobe itself
   localparam int FILL_DEAD   = 2;
   localparam logic [2:0] ACC_NO_PTE = 3'b111;

endpackage

// File: rtl/imr_seq.sv
module imr_seq
   import imr_pkg::*;
#(
   parameter int LAT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             miss_req,
   input  logic [LAT_W-1:0] stat_lat,
   input  logic [LAT_W-1:0] fill_lat,
   input  logic             abort_q,
   input  logic             cached,
   input  logic             last_dw,
   output logic             accept,
   output logic             stat_pulse,
   output logic             abort_pulse,
   output logic             bus_cycle,
   output logic             fill_pulse
);

   localparam int CNT_W = LAT_W + 1;

   generate
      if (LAT_W < 1) begin : g_bad_lat
         $error("imr_seq: LAT_W must be at least 1");
      end
   endgenerate

   imr_state_t       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             cnt_zero;
   logic             resp_fire;
   logic             fill_done;

   always_comb begin
      cnt_zero    = (cnt_q == '0);
      accept      = (state_q == ST_IDLE) && miss_req;
      resp_fire   = (state_q == ST_RESP) && cnt_zero;
      stat_pulse  = resp_fire && !abort_q;
      abort_pulse = resp_fire && abort_q;
      bus_cycle   = (state_q == ST_BUS);
      fill_pulse  = (state_q == ST_FILL) && cnt_zero;
      fill_done   = fill_pulse && (!cached || last_dw);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q <= ST_RESP;
                  cnt_q   <= CNT_W'(stat_lat);
               end
            end
            ST_RESP: begin
               if (resp_fire) begin
                  state_q <= abort_q ? ST_IDLE : ST_BUS;
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            ST_BUS: begin
               state_q <= ST_FILL;
               cnt_q   <= CNT_W'(fill_lat);
            end
            ST_FILL: begin
               if (fill_done) begin
                  state_q <= ST_IDLE;
               end else if (fill_pulse) begin
                  cnt_q <= CNT_W'(fill_lat) + CNT_W'(FILL_DEAD);
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R2: the status strobe is a single-cycle pulse
   p_stat_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      stat_pulse |=> !stat_pulse);

   // R2: the request line is still up when it is acknowledged
   p_stat_while_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      stat_pulse |-> miss_req);

   // R5: abort is a single pulse and never followed at once by status
   p_abort_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      abort_pulse |=> (!abort_pulse && !stat_pulse));

   // R6: no fill strobe in the status cycle nor the status-bus cycle
   p_first_fill_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stat_pulse |-> (!fill_pulse ##1 !fill_pulse));

   // R8: two empty cycles after every fill strobe
   p_fill_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fill_pulse |=> (!fill_pulse ##1 !fill_pulse));

endmodule

// File: rtl/imr_fill_ptr.sv
module imr_fill_ptr #(
   parameter int DWI_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic [DWI_W-1:0] start_dw,
   input  logic             fill_pulse,
   output logic [DWI_W-1:0] cur_dw,
   output logic             last_dw
);

   logic [DWI_W-1:0] start_q;
   logic [DWI_W-1:0] ptr_q;
   logic [DWI_W-1:0] ptr_inc;

   always_comb begin
      ptr_inc = ptr_q + DWI_W'(1);
      cur_dw  = ptr_q;
      // final strobe: the one whose successor wraps back to the start
      last_dw = (ptr_inc == start_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         ptr_q   <= '0;
      end else if (accept) begin
         start_q <= start_dw;
         ptr_q   <= start_dw;
      end else if (fill_pulse) begin
         ptr_q   <= ptr_inc;
      end
   end

   // R9: the pointer only moves by one per strobe
   p_ptr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_pulse && !accept) |=> (ptr_q == $past(ptr_inc)));

endmodule

// File: rtl/imr_stat_fmt.sv
module imr_stat_fmt
   import imr_pkg::*;
(
   input  logic              bus_cycle,
   input  logic              abort_pulse,
   input  logic              pte_valid,
   input  logic              cacheable,
   input  logic [2:0]        acc,
   input  logic [1:0]        lvl,
   output logic              eff_cached,
   output logic [STAT_W-1:0] stat_bus
);

   imr_stat_t full_stat;
   imr_stat_t lvl_only;

   always_comb begin
      eff_cached     = pte_valid ? cacheable : 1'b1;
      full_stat.lvl  = lvl;
      full_stat.acc  = pte_valid ? acc : ACC_NO_PTE;
      full_stat.cache = eff_cached;
      lvl_only       = '0;
      lvl_only.lvl   = lvl;
      if (bus_cycle) begin
         stat_bus = full_stat;
      end else if (abort_pulse) begin
         stat_bus = lvl_only;
      end else begin
         stat_bus = '0;
      end
   end

endmodule

// File: rtl/imr_data_gen.sv
module imr_data_gen
   import imr_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int LINE_W = 16,
   parameter int DWI_W  = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     fill_pulse,
   input  logic [LINE_W-1:0]        line,
   input  logic [DWI_W-1:0]         cur_dw,
   input  logic [DWI_W-1:0]         perr_dw,
   input  logic [DATA_W/WORD_W-1:0] perr_mask,
   output logic [DATA_W-1:0]        fill_data,
   output logic [DATA_W/WORD_W-1:0] fill_perr
);

   localparam int NW = DATA_W / WORD_W;

   generate
      if (DATA_W % WORD_W != 0 || NW < 1) begin : g_bad_data
         $error("imr_data_gen: DATA_W must be a multiple of 32");
      end
      if (LINE_W + DWI_W > WORD_W) begin : g_bad_line
         $error("imr_data_gen: line address plus index must fit a word");
      end
   endgenerate

   logic [WORD_W-1:0] base;
   assign base = WORD_W'({line, cur_dw});

   generate
      for (genvar w = 0; w < NW; w++) begin : g_word
         if (w % 2 == 0) begin : g_even
            assign fill_data[w*WORD_W +: WORD_W] = fill_pulse ? base : '0;
         end else begin : g_odd
            assign fill_data[w*WORD_W +: WORD_W] = fill_pulse ? ~base : '0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_perr <= '0;
      end else if (fill_pulse && (cur_dw == perr_dw)) begin
         fill_perr <= perr_mask;
      end else begin
         fill_perr <= '0;
      end
   end

   // R11: a parity flag only appears right after a fill strobe
   p_perr_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_perr != '0) |-> $past(fill_pulse));

endmodule

// File: rtl/imiss_responder.sv
module imiss_responder
   import imr_pkg::*;
#(
   parameter int LAT_W   = 4,
   parameter int LINE_W  = 16,
   parameter int DATA_W  = 64,
   parameter int LINE_DW = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         miss_req,
   input  logic                         cfg_abort,
   input  logic                         cfg_cacheable,
   input  logic                         cfg_pte_valid,
   input  logic [2:0]                   cfg_acc,
   input  logic [1:0]                   cfg_lvl,
   input  logic [LAT_W-1:0]             cfg_stat_lat,
   input  logic [LAT_W-1:0]             cfg_fill_lat,
   input  logic [$clog2(LINE_DW)-1:0]   cfg_dw,
   input  logic [LINE_W-1:0]            cfg_line,
   input  logic [$clog2(LINE_DW)-1:0]   cfg_perr_dw,
   input  logic [DATA_W/32-1:0]         cfg_perr,
   output logic                         stat_avail,
   output logic                         abort,
   output logic [5:0]                   stat_bus,
   output logic                         fill_stb,
   output logic [$clog2(LINE_DW)-1:0]   fill_dw,
   output logic [DATA_W-1:0]            fill_data,
   output logic [DATA_W/32-1:0]         fill_perr
);

   localparam int DWI_W = $clog2(LINE_DW);
   localparam int NW    = DATA_W / WORD_W;
   localparam int CNT_W = $clog2(LINE_DW + 1);

   generate
      if (LINE_DW < 2 || (LINE_DW & (LINE_DW - 1)) != 0) begin : g_bad_line_dw
         $error("imiss_responder: LINE_DW must be a power of two >= 2");
      end
      if (STAT_W != 6) begin : g_bad_stat
         $error("imiss_responder: status bus layout must be 6 bits");
      end
   endgenerate

   // request settings captured on acceptance
   logic              abort_q, pte_q, cache_q;
   logic [2:0]        acc_q;
   logic [1:0]        lvl_q;
   logic [LAT_W-1:0]  fill_lat_q;
   logic [LINE_W-1:0] line_q;
   logic [DWI_W-1:0]  perr_dw_q;
   logic [NW-1:0]     perr_q;

   logic accept, stat_pulse, abort_pulse, bus_cycle, fill_pulse;
   logic eff_cached, last_dw;
   logic [DWI_W-1:0] cur_dw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         abort_q    <= 1'b0;
         pte_q      <= 1'b0;
         cache_q    <= 1'b0;
         acc_q      <= '0;
         lvl_q      <= '0;
         fill_lat_q <= '0;
         line_q     <= '0;
         perr_dw_q  <= '0;
         perr_q     <= '0;
      end else if (accept) begin
         abort_q    <= cfg_abort;
         pte_q      <= cfg_pte_valid;
         cache_q    <= cfg_cacheable;
         acc_q      <= cfg_acc;
         lvl_q      <= cfg_lvl;
         fill_lat_q <= cfg_fill_lat;
         line_q     <= cfg_line;
         perr_dw_q  <= cfg_perr_dw;
         perr_q     <= cfg_perr;
      end
   end

   imr_seq #(.LAT_W(LAT_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .miss_req    (miss_req),
      .stat_lat    (cfg_stat_lat),
      .fill_lat    (fill_lat_q),
      .abort_q     (abort_q),
      .cached      (eff_cached),
      .last_dw     (last_dw),
      .accept      (accept),
      .stat_pulse  (stat_pulse),
      .abort_pulse (abort_pulse),
      .bus_cycle   (bus_cycle),
      .fill_pulse  (fill_pulse)
   );

   imr_fill_ptr #(.DWI_W(DWI_W)) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .start_dw   (cfg_dw),
      .fill_pulse (fill_pulse),
      .cur_dw     (cur_dw),
      .last_dw    (last_dw)
   );

   imr_stat_fmt u_fmt (
      .bus_cycle   (bus_cycle),
      .abort_pulse (abort_pulse),
      .pte_valid   (pte_q),
      .cacheable   (cache_q),
      .acc         (acc_q),
      .lvl         (lvl_q),
      .eff_cached  (eff_cached),
      .stat_bus    (stat_bus)
   );

   imr_data_gen #(.DATA_W(DATA_W), .LINE_W(LINE_W), .DWI_W(DWI_W)) u_data (
      .clk        (clk),
      .rst_n      (rst_n),
      .fill_pulse (fill_pulse),
      .line       (line_q),
      .cur_dw     (cur_dw),
      .perr_dw    (perr_dw_q),
      .perr_mask  (perr_q),
      .fill_data  (fill_data),
      .fill_perr  (fill_perr)
   );

   assign stat_avail = stat_pulse;
   assign abort      = abort_pulse;
   assign fill_stb   = fill_pulse;
   assign fill_dw    = fill_pulse ? cur_dw : '0;

   // checker state: strobes since the last status, and abort seen
   logic [CNT_W-1:0] chk_strobes_q;
   logic             chk_aborted_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_strobes_q <= '0;
         chk_aborted_q <= 1'b0;
      end else begin
         if (stat_avail) begin
            chk_strobes_q <= '0;
         end else if (fill_stb) begin
            chk_strobes_q <= chk_strobes_q + CNT_W'(1);
         end
         if (abort) begin
            chk_aborted_q <= 1'b1;
         end else if (accept) begin
            chk_aborted_q <= 1'b0;
         end
      end
   end

   // R7: never more than one line of strobes per status
   p_fill_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fill_stb |-> (chk_strobes_q < CNT_W'(LINE_DW)));

   // R5: an aborted request yields no fill and no status
   p_no_fill_after_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
      chk_aborted_q |-> (!fill_stb && !stat_avail));

   // R3: the status bus is quiet except right after status or during abort
   p_bus_after_stat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_bus != '0) && !abort) |-> $past(stat_avail));

   // R10: a noncacheable line never gets a second strobe
   p_nc_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_stb && !eff_cached) |-> (chk_strobes_q == '0));

endmodule

// File: tb/imiss_responder_bench.sv
module imiss_responder_bench;

   localparam int LAT_W   = 4;
   localparam int LINE_W  = 16;
   localparam int DATA_W  = 64;
   localparam int LINE_DW = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        miss_req = 1'b0;
   logic        cfg_abort = 1'b0;
   logic        cfg_cacheable = 1'b0;
   logic        cfg_pte_valid = 1'b0;
   logic [2:0]  cfg_acc = '0;
   logic [1:0]  cfg_lvl = '0;
   logic [3:0]  cfg_stat_lat = '0;
   logic [3:0]  cfg_fill_lat = '0;
   logic [1:0]  cfg_dw = '0;
   logic [15:0] cfg_line = '0;
   logic [1:0]  cfg_perr_dw = '0;
   logic [1:0]  cfg_perr = '0;
   logic        stat_avail, abort, fill_stb;
   logic [5:0]  stat_bus;
   logic [1:0]  fill_dw;
   logic [63:0] fill_data;
   logic [1:0]  fill_perr;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   imiss_responder #(.LAT_W(LAT_W), .LINE_W(LINE_W), .DATA_W(DATA_W),
                     .LINE_DW(LINE_DW)) u_imiss_responder (
      .clk(clk), .rst_n(rst_n), .miss_req(miss_req),
      .cfg_abort(cfg_abort), .cfg_cacheable(cfg_cacheable),
      .cfg_pte_valid(cfg_pte_valid), .cfg_acc(cfg_acc), .cfg_lvl(cfg_lvl),
      .cfg_stat_lat(cfg_stat_lat), .cfg_fill_lat(cfg_fill_lat),
      .cfg_dw(cfg_dw), .cfg_line(cfg_line), .cfg_perr_dw(cfg_perr_dw),
      .cfg_perr(cfg_perr), .stat_avail(stat_avail), .abort(abort),
      .stat_bus(stat_bus), .fill_stb(fill_stb), .fill_dw(fill_dw),
      .fill_data(fill_data), .fill_perr(fill_perr)
   );

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_quiet(string req, string what);
      chk(req, {what, " stat_avail"}, 64'(stat_avail), 64'd0);
      chk(req, {what, " abort"}, 64'(abort), 64'd0);
      chk(req, {what, " fill_stb"}, 64'(fill_stb), 64'd0);
      chk(req, {what, " stat_bus"}, 64'(stat_bus), 64'd0);
      chk(req, {what, " fill_data"}, fill_data, 64'd0);
      chk(req, {what, " fill_perr"}, 64'(fill_perr), 64'd0);
   endtask

   // one request from raise to completion, checked against the requirements
   task automatic run_case(string name, bit ab, bit cch, bit pte,
                           logic [2:0] acc, logic [1:0] lvl, int slat, int flat,
                           int dw, logic [15:0] line, int pdw, logic [1:0] pm,
                           bit hold);
      bit   eff_cached = pte ? cch : 1'b1;
      int   n_exp = ab ? 0 : (eff_cached ? 4 : 1);
      int   exp_stat = 1 + slat;
      logic [5:0] exp_bus = {lvl, (pte ? acc : 3'b111), eff_cached};
      int   nstat = 0;
      int   nabort = 0;
      int   nfill = 0;
      int   prev_fill = -10;
      int   prev_dw = 0;
      @(negedge clk);
      cfg_abort = ab; cfg_cacheable = cch; cfg_pte_valid = pte;
      cfg_acc = acc; cfg_lvl = lvl; cfg_stat_lat = 4'(slat);
      cfg_fill_lat = 4'(flat); cfg_dw = 2'(dw); cfg_line = line;
      cfg_perr_dw = 2'(pdw); cfg_perr = pm;
      miss_req = 1'b1;
      for (int c = 1; c <= 80; c++) begin
         @(negedge clk);
         if (prev_fill == c - 1) begin
            chk("R11", {name, " parity flag"}, 64'(fill_perr),
                (prev_dw == pdw) ? 64'(pm) : 64'd0);
         end
         if (stat_avail) begin
            nstat++;
            chk("R2", {name, " status cycle"}, 64'(c), 64'(exp_stat));
         end
         if (abort) begin
            nabort++;
            chk("R5", {name, " abort cycle"}, 64'(c), 64'(exp_stat));
            chk("R5", {name, " abort bus"}, 64'(stat_bus), 64'({lvl, 4'b0000}));
            miss_req = 1'b0;
         end
         if (!ab && c == exp_stat + 1) begin
            chk(pte ? "R3" : "R4", {name, " status bus"}, 64'(stat_bus), 64'(exp_bus));
            if (!hold) miss_req = 1'b0;
         end
         if (fill_stb) begin
            int exp_c = exp_stat + 2 + flat + nfill * (3 + flat);
            int exp_dw = (dw + nfill) % LINE_DW;
            logic [31:0] lo = 32'({line, 2'(exp_dw)});
            chk((nfill == 0) ? "R6" : "R8", {name, " strobe cycle"}, 64'(c), 64'(exp_c));
            chk(eff_cached ? "R9" : "R10", {name, " strobe index"}, 64'(fill_dw), 64'(exp_dw));
            chk("R7", {name, " fill data"}, fill_data, {~lo, lo});
            if (hold && nfill == n_exp - 1) miss_req = 1'b0;
            prev_fill = c;
            prev_dw = int'(fill_dw);
            nfill++;
         end
      end
      miss_req = 1'b0;
      chk("R12", {name, " status count"}, 64'(nstat), ab ? 64'd0 : 64'd1);
      chk("R5", {name, " abort count"}, 64'(nabort), ab ? 64'd1 : 64'd0);
      chk(eff_cached ? "R7" : "R10", {name, " strobe count"}, 64'(nfill), 64'(n_exp));
      chk_quiet("R12", {name, " idle after"});
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk_quiet("R1", "in reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk_quiet("R1", "after reset");
   endtask

   task automatic t_cached_wrap;       // R9 wrap from mid-line, minimum latency
      run_case("cached wrap", 0, 1, 1, 3'b101, 2'b10, 0, 0, 2, 16'h1234, 0, 2'b00, 0);
   endtask

   task automatic t_cached_slow;       // R8 spacing with slack, R11 high word
      run_case("cached slow", 0, 1, 1, 3'b010, 2'b01, 3, 4, 0, 16'h00A5, 1, 2'b10, 0);
   endtask

   task automatic t_noncached;         // R10 single strobe, R11 low word
      run_case("noncached", 0, 0, 1, 3'b110, 2'b11, 1, 2, 3, 16'hBEEF, 3, 2'b01, 0);
   endtask

   task automatic t_default_status;    // R4 no page-table entry
      run_case("no entry", 0, 0, 0, 3'b000, 2'b01, 2, 0, 1, 16'h0F0F, 2, 2'b11, 0);
   endtask

   task automatic t_abort;             // R5
      run_case("abort", 1, 1, 1, 3'b011, 2'b10, 2, 0, 0, 16'h7777, 0, 2'b11, 0);
   endtask

   task automatic t_hold;              // R12 request held through the fill
      run_case("held cached", 0, 1, 1, 3'b001, 2'b00, 0, 1, 3, 16'h4242, 0, 2'b00, 1);
      run_case("held noncached", 0, 0, 1, 3'b100, 2'b01, 1, 0, 1, 16'h0101, 1, 2'b11, 1);
   endtask

   task automatic t_after_abort;       // R12 recovery after abort
      run_case("quick abort", 1, 0, 1, 3'b111, 2'b11, 0, 0, 2, 16'h0A0A, 0, 2'b00, 0);
      run_case("after abort", 0, 1, 1, 3'b011, 2'b10, 0, 2, 1, 16'h5555, 1, 2'b01, 0);
   endtask

   initial begin
      t_reset();
      t_cached_wrap();
      t_cached_slow();
      t_noncached();
      t_default_status();
      t_abort();
      t_hold();
      t_after_abort();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule